// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block lets synchronous logic use an external 32K x 8 asynchronous static RAM. The RAM has a shared data bus and three active-low strobes: chip select, write enable and output enable. The user side is a single-request port. A request is accepted when `req_valid` and `req_ready` are both high on a clock edge. It carries a 15-bit address, a write flag and one byte of write data. A read returns its byte on `rd_data` together with a one-cycle `rd_valid` pulse.

The block runs from a fast system clock and makes every strobe from a register. It turns each minimum time of the memory into a whole number of clock cycles. Each count is the time parameter divided by the clock period, rounded up, and never less than one. The shared data bus is split into `mem_dq_out`, `mem_dq_in` and a drive enable `mem_dq_oe`, which the pad ring uses as its tri-state control.

Writes keep output enable high for the whole cycle, so the shorter write pulse of the memory applies. The controller turns its bus driver on only after write enable is low and the memory's output has had time to go high-impedance. It turns the driver off on the same edge where write enable rises. Between operations chip select stays high, so the memory sits in standby.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: A synchronous active-low reset sets `mem_cs_n`, `mem_we_n` and `mem_oe_n` high, sets `mem_dq_oe` and `rd_valid` low, and makes `req_ready` high.
- R2: While no access is in progress (`req_ready` high), all three strobes are high and the bus driver is off, so the memory is deselected.
- R3: A write holds chip select and write enable low with output enable high. A read holds chip select and output enable low with write enable high. Output enable and write enable are never low together, and `mem_dq_oe` is high only while a write is in progress.
- R4: `mem_dq_oe` rises only on an edge where write enable is already low, and only after output enable has been high for at least HZ cycles, where HZ = ceil(T_HZ_PS / CLK_PS).
- R5: Every write enable low pulse lasts at least WP = ceil(T_WP_PS / CLK_PS) cycles.
- R6: Data is driven for at least DS = ceil(T_DW_PS / CLK_PS) cycles before write enable rises. `mem_dq_oe` falls on the same edge where write enable rises. `mem_dq_out` does not change while write enable is low.
- R7: A read holds output enable low for exactly RD = max(ceil(T_AA_PS / CLK_PS), ceil(T_RC_PS / CLK_PS)) cycles. The bus is sampled on the edge that ends that count, which is the edge where output enable rises. `rd_valid` is high for the one following cycle, with the sampled byte on `rd_data`.
- R8: When a read follows a write, output enable falls no earlier than the second edge after write enable rises. This leaves at least one whole cycle with all strobes high between the two operations.
- R9: `mem_addr` does not change while chip select stays low.
- R10: `req_ready` is high only while the block is idle. Accepted requests are served in order, and each read produces exactly one `rd_valid` pulse.
- R11: Each cycle count is the time divided by the clock period, rounded up, with a minimum of one. The default parameters (2.5 ns clock) give WP = 4, DS = 2, RD = 4 and HZ = 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; the request is taken on this edge |
| req_addr | input | 15 | Word address of the request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Byte to write |
| rd_valid | output | 1 | One-cycle pulse, read byte present |
| rd_data | output | 8 | Byte returned by the last read |
| mem_addr | output | 15 | Address lines to the memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Byte driven onto the shared bus |
| mem_dq_oe | output | 1 | Tri-state enable for the bus driver, 1 = drive |
| mem_dq_in | input | 8 | Byte seen on the shared bus |

## Verification
The bench models a memory with two behaviours. It returns a wrong byte until the access time has passed, so a controller that samples early reads that byte. It also keeps driving the bus for the high-impedance window after output enable rises, so a write that turns its driver on too soon right after a read is counted as contention. Writes are stored by the model only when write enable rises. A controller that drops its driver before that edge, or cuts the pulse or the data setup short, therefore reads back the wrong value or fails the width checks. Back-to-back write then read is checked for the idle cycle. Read then write is checked for the turnaround gap. The address extremes and a walking-one pattern catch an address or data line that is swapped or stuck.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and helpers for the SRAM strobe sequencer.
// Assumes every time parameter is given in picoseconds and is non-negative.
package sram_ctrl_pkg;

    // Sequencer states: idle, write-to-read gap, write before driving,
    // write with data driven, read access.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_WR_WAIT,
        ST_WR_DRIVE,
        ST_RD_ACC
    } seq_state_t;

    // Whole clock cycles needed to cover t_ps, rounded up, never below one.
    function automatic int cyc_ceil(input int t_ps, input int clk_ps);
        int c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        if (c < 1) begin
            c = 1;
        end
        return c;
    endfunction

    // Larger of two integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_req_latch.sv
// Request holding register: keeps address and write byte of the accepted
// request on the memory pins until the next request is accepted.
// Assumes accept is only high while the sequencer is idle, so the address
// never moves while chip select is low.
module sram_req_latch #(
    parameter int AW     = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [AW-1:0]     req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [AW-1:0]     op_addr,
    output logic [DATA_W-1:0] op_wdata
);

    // Capture address and data of an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_addr  <= '0;
            op_wdata <= '0;
        end else if (accept) begin
            op_addr  <= req_addr;
            op_wdata <= req_wdata;
        end
    end

endmodule

// File: rtl/sram_bus_guard.sv
// Bus turnaround guard: counts the cycles output enable has been high and
// reports when the memory has surely released the shared bus.
// Assumes oe_n is the registered strobe that drives the memory pin.
module sram_bus_guard #(
    parameter int HZ_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oe_n,
    output logic bus_quiet
);

    localparam int CW = $clog2(HZ_CYC + 1) + 1;

    logic [CW-1:0] hi_cnt_q;

    // Saturating count of edges seen with output enable high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt_q <= CW'(HZ_CYC);
        end else if (!oe_n) begin
            hi_cnt_q <= '0;
        end else if (int'(hi_cnt_q) < HZ_CYC) begin
            hi_cnt_q <= hi_cnt_q + CW'(1);
        end
    end

    // Quiet when the edge now coming completes HZ_CYC high cycles.
    assign bus_quiet = oe_n && (int'(hi_cnt_q) >= HZ_CYC - 1);

endmodule

// File: rtl/sram_strobe_fsm.sv
// Strobe sequencer: walks each access through its states, counts the
// pulse and access windows and registers every strobe so the memory sees
// glitch-free edges.
// Assumes op_we is valid on the accepting edge and bus_quiet comes from the
// turnaround guard watching this block's own output enable.
module sram_strobe_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int WP_CYC = 4,
    parameter int DS_CYC = 2,
    parameter int RD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic op_we,
    input  logic bus_quiet,
    output logic idle,
    output logic cs_n,
    output logic we_n,
    output logic oe_n,
    output logic dq_oe,
    output logic capture
);

    localparam int CNT_MAX = imax(imax(WP_CYC, DS_CYC), RD_CYC);
    localparam int CW      = $clog2(CNT_MAX + 1) + 1;

    seq_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] dcnt_q, dcnt_d;
    logic          last_wr_q, last_wr_d;
    logic          cnt_sat;
    logic          wr_done;
    logic          rd_done;

    // Window conditions evaluated on the current edge.
    assign cnt_sat = (int'(cnt_q) >= CNT_MAX);
    assign wr_done = (int'(cnt_q) >= WP_CYC) && (int'(dcnt_q) >= DS_CYC);
    assign rd_done = (int'(cnt_q) >= RD_CYC);

    // Next-state and counter logic for every access kind.
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        dcnt_d    = dcnt_q;
        last_wr_d = last_wr_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    cnt_d  = CW'(1);
                    dcnt_d = '0;
                    if (op_we) begin
                        state_d = ST_WR_WAIT;
                    end else if (last_wr_q) begin
                        state_d = ST_TURN;
                    end else begin
                        state_d = ST_RD_ACC;
                    end
                end
            end
            ST_TURN: begin
                state_d = ST_RD_ACC;
                cnt_d   = CW'(1);
            end
            ST_WR_WAIT: begin
                if (!cnt_sat) begin
                    cnt_d = cnt_q + CW'(1);
                end
                if (bus_quiet) begin
                    state_d = ST_WR_DRIVE;
                    dcnt_d  = CW'(1);
                end
            end
            ST_WR_DRIVE: begin
                if (wr_done) begin
                    state_d   = ST_IDLE;
                    last_wr_d = 1'b1;
                end else begin
                    if (!cnt_sat) begin
                        cnt_d = cnt_q + CW'(1);
                    end
                    if (int'(dcnt_q) < CNT_MAX) begin
                        dcnt_d = dcnt_q + CW'(1);
                    end
                end
            end
            ST_RD_ACC: begin
                if (rd_done) begin
                    state_d   = ST_IDLE;
                    last_wr_d = 1'b0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            dcnt_q    <= '0;
            last_wr_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            cnt_q     <= cnt_d;
            dcnt_q    <= dcnt_d;
            last_wr_q <= last_wr_d;
        end
    end

    // Strobes registered from the next state so each pin has one flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n  <= 1'b1;
            we_n  <= 1'b1;
            oe_n  <= 1'b1;
            dq_oe <= 1'b0;
        end else begin
            cs_n  <= !(state_d == ST_WR_WAIT || state_d == ST_WR_DRIVE ||
                       state_d == ST_RD_ACC);
            we_n  <= !(state_d == ST_WR_WAIT || state_d == ST_WR_DRIVE);
            oe_n  <= !(state_d == ST_RD_ACC);
            dq_oe <= (state_d == ST_WR_DRIVE);
        end
    end

    // Idle flag and read-sample strobe for the top level.
    assign idle    = (state_q == ST_IDLE);
    assign capture = (state_q == ST_RD_ACC) && rd_done;

endmodule

// File: rtl/sram_strobe_ctrl.sv
// Top of the asynchronous SRAM strobe sequencer. Takes one request at a
// time over a valid/ready port, drives the memory strobes, the address and
// the bus driver enable, and returns read bytes with a one-cycle pulse.
// Assumes the pad ring joins mem_dq_out / mem_dq_oe / mem_dq_in into one
// tri-state bus, and that the time parameters suit the fitted speed grade.
module sram_strobe_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int AW      = 15,
    parameter int DATA_W  = 8,
    parameter int CLK_PS  = 2500,
    parameter int T_WP_PS = 8000,
    parameter int T_DW_PS = 5000,
    parameter int T_AA_PS = 10000,
    parameter int T_RC_PS = 10000,
    parameter int T_HZ_PS = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [AW-1:0]     req_addr,
    input  logic              req_we,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int WP_CYC = cyc_ceil(T_WP_PS, CLK_PS);
    localparam int DS_CYC = cyc_ceil(T_DW_PS, CLK_PS);
    localparam int RD_CYC = imax(cyc_ceil(T_AA_PS, CLK_PS), cyc_ceil(T_RC_PS, CLK_PS));
    localparam int HZ_CYC = cyc_ceil(T_HZ_PS, CLK_PS);

    logic idle;
    logic accept;
    logic bus_quiet;
    logic capture;

    assign req_ready = idle;
    assign accept    = req_valid && idle;

    sram_req_latch #(
        .AW     (AW),
        .DATA_W (DATA_W)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .op_addr   (mem_addr),
        .op_wdata  (mem_dq_out)
    );

    sram_bus_guard #(
        .HZ_CYC (HZ_CYC)
    ) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .oe_n      (mem_oe_n),
        .bus_quiet (bus_quiet)
    );

    sram_strobe_fsm #(
        .WP_CYC (WP_CYC),
        .DS_CYC (DS_CYC),
        .RD_CYC (RD_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .op_we     (req_we),
        .bus_quiet (bus_quiet),
        .idle      (idle),
        .cs_n      (mem_cs_n),
        .we_n      (mem_we_n),
        .oe_n      (mem_oe_n),
        .dq_oe     (mem_dq_oe),
        .capture   (capture)
    );

    // Sample the bus at the end of the access window and flag it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= capture;
            if (capture) begin
                rd_data <= mem_dq_in;
            end
        end
    end

endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
// Protocol checker for the SRAM strobe sequencer, bound to the top level.
// Measures strobe windows with its own saturating counters.
module sram_strobe_ctrl_chk
    import sram_ctrl_pkg::*;
#(
    parameter int AW      = 15,
    parameter int DATA_W  = 8,
    parameter int CLK_PS  = 2500,
    parameter int T_WP_PS = 8000,
    parameter int T_DW_PS = 5000,
    parameter int T_AA_PS = 10000,
    parameter int T_RC_PS = 10000,
    parameter int T_HZ_PS = 5000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [AW-1:0]     mem_addr,
    input logic              mem_cs_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);

    localparam int WP_CYC = cyc_ceil(T_WP_PS, CLK_PS);
    localparam int DS_CYC = cyc_ceil(T_DW_PS, CLK_PS);
    localparam int RD_CYC = imax(cyc_ceil(T_AA_PS, CLK_PS), cyc_ceil(T_RC_PS, CLK_PS));
    localparam int HZ_CYC = cyc_ceil(T_HZ_PS, CLK_PS);
    localparam logic [15:0] SAT = 16'hFFFF;

    logic [15:0] we_lo_cnt, dq_on_cnt, oe_hi_cnt, oe_lo_cnt, we_hi_cnt;

    // Window counters: cycles each strobe has spent in its current level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_lo_cnt <= '0;
            dq_on_cnt <= '0;
            oe_lo_cnt <= '0;
            oe_hi_cnt <= SAT;
            we_hi_cnt <= SAT;
        end else begin
            we_lo_cnt <= mem_we_n  ? '0 : ((we_lo_cnt == SAT) ? SAT : we_lo_cnt + 16'd1);
            dq_on_cnt <= !mem_dq_oe ? '0 : ((dq_on_cnt == SAT) ? SAT : dq_on_cnt + 16'd1);
            oe_lo_cnt <= mem_oe_n  ? '0 : ((oe_lo_cnt == SAT) ? SAT : oe_lo_cnt + 16'd1);
            oe_hi_cnt <= !mem_oe_n ? '0 : ((oe_hi_cnt == SAT) ? SAT : oe_hi_cnt + 16'd1);
            we_hi_cnt <= !mem_we_n ? '0 : ((we_hi_cnt == SAT) ? SAT : we_hi_cnt + 16'd1);
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rd_valid));

    assert_standby_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe));

    assert_no_oe_we_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_cs_n));

    assert_drive_only_in_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && !mem_cs_n && mem_oe_n));

    assert_drive_after_we_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> !$past(mem_we_n));

    assert_turnaround_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (int'(oe_hi_cnt) >= HZ_CYC));

    assert_write_pulse_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (int'(we_lo_cnt) >= WP_CYC));

    assert_data_setup_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (int'(dq_on_cnt) >= DS_CYC));

    assert_driver_off_with_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> $fell(mem_dq_oe));

    assert_data_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dq_out));

    assert_read_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (int'(oe_lo_cnt) == RD_CYC));

    assert_valid_at_read_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $rose(mem_oe_n));

    assert_idle_between_wr_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> (we_hi_cnt >= 16'd2));

    assert_addr_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(
    .AW      (AW),
    .DATA_W  (DATA_W),
    .CLK_PS  (CLK_PS),
    .T_WP_PS (T_WP_PS),
    .T_DW_PS (T_DW_PS),
    .T_AA_PS (T_AA_PS),
    .T_RC_PS (T_RC_PS),
    .T_HZ_PS (T_HZ_PS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid),
    .mem_addr   (mem_addr),
    .mem_cs_n   (mem_cs_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_strobe_ctrl_tb.sv
// Scoreboard bench with a behavioural memory that honours access time and
// output release time.
module sram_strobe_ctrl_tb;

    localparam int CLK_PS = 2500;
    localparam int WP_N   = (8000 + CLK_PS - 1) / CLK_PS;
    localparam int DS_N   = (5000 + CLK_PS - 1) / CLK_PS;
    localparam int AA_N   = (10000 + CLK_PS - 1) / CLK_PS;
    localparam int RC_N   = (10000 + CLK_PS - 1) / CLK_PS;
    localparam int RD_N   = (AA_N > RC_N) ? AA_N : RC_N;
    localparam int HZ_N   = (5000 + CLK_PS - 1) / CLK_PS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [14:0] req_addr = '0;
    logic        req_we = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [14:0] mem_addr;
    logic        mem_cs_n, mem_we_n, mem_oe_n;
    logic [7:0]  mem_dq_out;
    logic        mem_dq_oe;
    logic [7:0]  mem_dq_in;

    always #5 clk = ~clk;

    sram_strobe_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_we     (req_we),
        .req_wdata  (req_wdata),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .mem_addr   (mem_addr),
        .mem_cs_n   (mem_cs_n),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .mem_dq_in  (mem_dq_in)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Memory model: stores on write-enable rise, drives junk until access time.
    logic [7:0] model_mem [int];
    logic [7:0] exp_mem [int];
    logic [7:0] exp_q [$];
    int rd_run = 0;

    always @(posedge clk) begin
        rd_run <= (!mem_cs_n && !mem_oe_n && mem_we_n) ? rd_run + 1 : 0;
    end

    always @* begin
        if (!mem_cs_n && !mem_oe_n && mem_we_n && rd_run >= AA_N - 1)
            mem_dq_in = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 8'h00;
        else
            mem_dq_in = 8'hEE;
    end

    // Monitor: window measurement, model commit and scoreboard compare.
    logic        p_we_n = 1'b1, p_oe_n = 1'b1, p_cs_n = 1'b1, p_dq_oe = 1'b0;
    logic [14:0] p_addr = '0;
    logic [7:0]  last_data = '0;
    int we_lo = 0, dq_on = 0, oe_lo = 0;
    int oe_hi = 1000, we_hi = 1000;
    int contention = 0, addr_moves = 0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (!p_we_n && mem_we_n) begin
                check(we_lo >= WP_N, "R5", "write pulse cycles", we_lo, WP_N);
                check(dq_on >= DS_N, "R6", "data setup cycles", dq_on, DS_N);
                check(!mem_dq_oe, "R6", "driver off at WE rise", int'(mem_dq_oe), 0);
                model_mem[int'(p_addr)] = last_data;
            end
            if (!p_dq_oe && mem_dq_oe) begin
                check(oe_hi >= HZ_N, "R4", "OE high before drive", oe_hi, HZ_N);
                check(!p_we_n, "R4", "WE low before drive", int'(p_we_n), 0);
            end
            if (p_oe_n && !mem_oe_n)
                check(we_hi >= 2, "R8", "cycles from WE rise to OE fall", we_hi, 2);
            if (!p_oe_n && mem_oe_n)
                check(oe_lo == RD_N, "R7 R11", "OE low cycles", oe_lo, RD_N);
            if (mem_dq_oe && (!mem_oe_n || oe_hi < HZ_N))
                contention++;
            if (!p_cs_n && !mem_cs_n && mem_addr != p_addr)
                addr_moves++;
            if (rd_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10", "unexpected rd_valid", 1, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(rd_data == e, "R7", "read byte", int'(rd_data), int'(e));
                end
            end
            we_lo = mem_we_n ? 0 : we_lo + 1;
            dq_on = mem_dq_oe ? dq_on + 1 : 0;
            oe_lo = mem_oe_n ? 0 : oe_lo + 1;
            oe_hi = mem_oe_n ? oe_hi + 1 : 0;
            we_hi = mem_we_n ? we_hi + 1 : 0;
            if (mem_dq_oe) last_data = mem_dq_out;
        end
        p_we_n  = mem_we_n;
        p_oe_n  = mem_oe_n;
        p_cs_n  = mem_cs_n;
        p_dq_oe = mem_dq_oe;
        p_addr  = mem_addr;
    end

    // Driver: called at a negedge; returns at a negedge after acceptance.
    task automatic issue(input bit we, input logic [14:0] a, input logic [7:0] d);
        req_valid = 1'b1;
        req_we    = we;
        req_addr  = a;
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        if (we) exp_mem[int'(a)] = d;
        else exp_q.push_back(exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 8'h00);
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R10", "ready low while busy", int'(req_ready), 0);
    endtask

    task automatic standby_check(input string tag);
        repeat (RD_N + WP_N + 4) @(negedge clk);
        check(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready, tag,
              "standby strobes {cs,we,oe,dq_oe,ready}",
              int'({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready}), 5'b11101);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R10 watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rd_valid, "R1",
              "strobes in reset", int'({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, rd_valid}), 5'b11100);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && mem_cs_n, "R1", "ready after reset", int'(req_ready), 1);

        // Back-to-back writes at address extremes.
        issue(1'b1, 15'h0000, 8'h3C);
        issue(1'b1, 15'h7FFF, 8'hA5);
        issue(1'b1, 15'h1234, 8'h81);
        issue(1'b1, 15'h5555, 8'h7E);
        // Read after read.
        issue(1'b0, 15'h7FFF, 8'h00);
        issue(1'b0, 15'h0000, 8'h00);
        standby_check("R2");
        // Write then read of the same word (R8 gap).
        issue(1'b1, 15'h1234, 8'h42);
        issue(1'b0, 15'h1234, 8'h00);
        // Read then write (R4 turnaround), then read back.
        issue(1'b0, 15'h5555, 8'h00);
        issue(1'b1, 15'h5555, 8'h19);
        issue(1'b0, 15'h5555, 8'h00);
        // Unwritten word reads as the model's default.
        issue(1'b0, 15'h0ABC, 8'h00);
        standby_check("R2");
        // Walking one on address and data lines.
        for (int i = 0; i < 8; i++) begin
            issue(1'b1, 15'(1 << (i + 7)), 8'(1 << i));
        end
        for (int i = 0; i < 8; i++) begin
            issue(1'b0, 15'(1 << (i + 7)), 8'h00);
        end
        while (exp_q.size() != 0) @(negedge clk);
        standby_check("R2");
        check(exp_q.size() == 0, "R10", "reads left unanswered", exp_q.size(), 0);
        check(contention == 0, "R3", "bus contention cycles", contention, 0);
        check(addr_moves == 0, "R9", "address moves under CS", addr_moves, 0);
        done = 1'b1;
        finish_run();
    end

endmodule